// File: doc/BRIEF.md
# Condition Register Field Unit

This block keeps a 32-bit condition register divided into eight 4-bit fields. Each field can be written on its own. Three sources produce whole-field flag updates. An integer result lands in field 0 with no select. A floating-point flag nibble lands in field 1 with no select. A compare lands in whichever field a 3-bit select names.

A fourth source combines two single register bits with one of eight logical functions and writes the result into a single destination bit. Branch logic reads any one bit through a 5-bit index on a combinational test port. The whole register is also visible as a flat output.

All writes take effect on the clock edge after the request. Sources always read the register value from before that edge. When several requests reach the same field in one cycle, a fixed priority picks the one that wins. Requests aimed at different fields all take effect together.

Top module: `cr_field_unit`

## Requirements
- R1: While reset is applied, and on the first cycle after it, `cr_out` reads all zeros.
- R2: Field f sits at `cr_out[31-4f : 28-4f]`. Field 0 is therefore bits 31:28 and field 7 is bits 3:0. From most to least significant, a field holds less-than, greater-than, equal and summary-overflow. Bit index i (0..31) names `cr_out[31-i]`, so index 4f+0 is the less-than bit of field f and index 4f+3 is its summary-overflow bit.
- R3: When `int_vld` is high, field 0 takes the result of comparing `int_value` with zero on the next edge. The comparison is two's-complement when `int_signed` is 1 and unsigned otherwise. The summary-overflow bit takes `int_ovf_sticky`.
- R4: When `fp_vld` is high, field 1 takes `fp_flags` unchanged on the next edge, with `fp_flags[3]` landing in the less-than position.
- R5: When `cmp_vld` is high, field `cmp_field` takes the result of comparing `cmp_lhs` with `cmp_rhs` on the next edge. The comparison is signed when `cmp_signed` is 1. The summary-overflow bit takes `cmp_ovf_sticky`. Exactly one of less-than, greater-than and equal is set.
- R6: When `bop_vld` is high, bit `bop_dst` takes f(bit `bop_src_a`, bit `bop_src_b`). The function is chosen by `bop_op`: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 EQV (XNOR), 6 ANDC (a AND NOT b), 7 ORC (a OR NOT b). The other 31 bits keep their value. Both sources are read from the register before the edge.
- R7: When several requests target one field in the same cycle, only one of them has any effect on that field. The compare wins over the bit operation, the bit operation over the integer update, and the integer update over the floating-point update.
- R8: `test_bit` equals `cr_out[31-test_idx]` in the same cycle, with no register between them.
- R9: With no valid request, every bit of `cr_out` holds its value.
- R10: Requests that target different fields in the same cycle all take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_vld | input | 1 | Integer flag update request (field 0) |
| int_value | input | OPND_W | Integer result compared with zero |
| int_signed | input | 1 | 1: signed comparison for the integer update |
| int_ovf_sticky | input | 1 | Summary-overflow value for the integer update |
| fp_vld | input | 1 | Floating-point flag update request (field 1) |
| fp_flags | input | 4 | Ready-made flag nibble for field 1 |
| cmp_vld | input | 1 | Compare update request |
| cmp_field | input | 3 | Target field of the compare |
| cmp_lhs | input | OPND_W | Left compare operand |
| cmp_rhs | input | OPND_W | Right compare operand |
| cmp_signed | input | 1 | 1: signed comparison |
| cmp_ovf_sticky | input | 1 | Summary-overflow value for the compare |
| bop_vld | input | 1 | Bit operation request |
| bop_op | input | 3 | Logical function code (see R6) |
| bop_src_a | input | 5 | First source bit index |
| bop_src_b | input | 5 | Second source bit index |
| bop_dst | input | 5 | Destination bit index |
| test_idx | input | 5 | Bit index for the branch test port |
| test_bit | output | 1 | Selected register bit |
| cr_out | output | 32 | Whole condition register |

## Verification
Each field has its own register. A wrong field enable or a wrong priority decision therefore shows up as a stale or foreign nibble on `cr_out` one edge after the request. It also shows up on `test_bit` in the same cycle that anything reads the bad bit. A flaw in the bit-index mapping or the operation decode stays hidden until a later bit operation or test uses that bit. For that reason the sweeps read every index back and chain operations on results they have just produced. The compare sweep covers every operand pair of a 4-bit configuration in both signed and unsigned modes. It rotates through all eight fields, so an error in sign handling or field selection appears on the very next edge.

// File: rtl/cr_pkg.sv
package cr_pkg;

  localparam int FIELD_W = 4;

  // position of each flag counted from the field MSB
  localparam int FLG_LT = 0;
  localparam int FLG_GT = 1;
  localparam int FLG_EQ = 2;
  localparam int FLG_SO = 3;

  typedef enum logic [2:0] {
    CRB_AND  = 3'd0,
    CRB_OR   = 3'd1,
    CRB_XOR  = 3'd2,
    CRB_NAND = 3'd3,
    CRB_NOR  = 3'd4,
    CRB_EQV  = 3'd5,
    CRB_ANDC = 3'd6,
    CRB_ORC  = 3'd7
  } crb_op_e;

endpackage

// File: rtl/cr_flag_gen.sv
module cr_flag_gen #(
  parameter int OPND_W = 32
) (
  input  logic [OPND_W-1:0]          lhs,
  input  logic [OPND_W-1:0]          rhs,
  input  logic                       is_signed,
  input  logic                       ovf_sticky,
  output logic [cr_pkg::FIELD_W-1:0] flags
);
  import cr_pkg::*;

  logic lt_s, lt_u, lt, eq, gt;

  always_comb begin
    lt_s = $signed(lhs) < $signed(rhs);
    lt_u = lhs < rhs;
    eq   = lhs == rhs;
    lt   = is_signed ? lt_s : lt_u;
    gt   = !lt && !eq;
    flags = '0;
    flags[FIELD_W-1-FLG_LT] = lt;
    flags[FIELD_W-1-FLG_GT] = gt;
    flags[FIELD_W-1-FLG_EQ] = eq;
    flags[FIELD_W-1-FLG_SO] = ovf_sticky;
  end

endmodule

// File: rtl/cr_bit_op.sv
module cr_bit_op #(
  parameter int CR_W  = 32,
  parameter int IDX_W = 5
) (
  input  logic [CR_W-1:0]  cr_cur,
  input  logic [2:0]       op,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  output logic             result
);
  import cr_pkg::*;

  logic    bit_a, bit_b;
  crb_op_e op_e;

  always_comb begin
    bit_a = cr_cur[CR_W-1-int'(src_a)];
    bit_b = cr_cur[CR_W-1-int'(src_b)];
    op_e  = crb_op_e'(op);
    case (op_e)
      CRB_AND:  result = bit_a & bit_b;
      CRB_OR:   result = bit_a | bit_b;
      CRB_XOR:  result = bit_a ^ bit_b;
      CRB_NAND: result = ~(bit_a & bit_b);
      CRB_NOR:  result = ~(bit_a | bit_b);
      CRB_EQV:  result = ~(bit_a ^ bit_b);
      CRB_ANDC: result = bit_a & ~bit_b;
      CRB_ORC:  result = bit_a | ~bit_b;
      default:  result = 1'b0;
    endcase
  end

endmodule

// File: rtl/cr_field_slot.sv
module cr_field_slot #(
  parameter int FW = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_hit,
  input  logic [FW-1:0] cmp_flags,
  input  logic          bop_hit,
  input  logic [PW-1:0] bop_pos,
  input  logic          bop_bit,
  input  logic          int_hit,
  input  logic [FW-1:0] int_flags,
  input  logic          fp_hit,
  input  logic [FW-1:0] fp_flags,
  output logic [FW-1:0] field_q
);

  logic [FW-1:0] field_d;
  logic          field_en;

  always_comb begin
    field_en = cmp_hit | bop_hit | int_hit | fp_hit;
    field_d  = field_q;
    if (cmp_hit) begin
      field_d = cmp_flags;
    end else if (bop_hit) begin
      field_d[FW-1-int'(bop_pos)] = bop_bit;
    end else if (int_hit) begin
      field_d = int_flags;
    end else if (fp_hit) begin
      field_d = fp_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
    end else if (field_en) begin
      field_q <= field_d;
    end
  end

  // R7: compare owns the field when present
  a_r7_cmp_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> field_q == $past(cmp_flags));

  // R7: integer beats floating point when nothing higher targets the field
  a_r7_int_over_fp: assert property (@(posedge clk) disable iff (!rst_n)
    (int_hit && !cmp_hit && !bop_hit) |=> field_q == $past(int_flags));

  // R6: destination bit takes the operation result
  a_r6_bop_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bop_hit && !cmp_hit) |=> field_q[FW-1-int'($past(bop_pos))] == $past(bop_bit));

  // R5: a compare raises exactly one relation flag
  a_r5_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |-> $countones(cmp_flags[FW-1:1]) == 1);

  // R9: no request leaves the field untouched
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_hit || bop_hit || int_hit || fp_hit) |=> $stable(field_q));

endmodule

// File: rtl/cr_field_unit.sv
module cr_field_unit #(
  parameter int NUM_FIELDS = 8,
  parameter int OPND_W     = 32,
  localparam int FW        = cr_pkg::FIELD_W,
  localparam int CR_W      = NUM_FIELDS * FW,
  localparam int IDX_W     = $clog2(CR_W),
  localparam int SEL_W     = $clog2(NUM_FIELDS),
  localparam int PW        = $clog2(FW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_vld,
  input  logic [OPND_W-1:0] int_value,
  input  logic              int_signed,
  input  logic              int_ovf_sticky,
  input  logic              fp_vld,
  input  logic [FW-1:0]     fp_flags,
  input  logic              cmp_vld,
  input  logic [SEL_W-1:0]  cmp_field,
  input  logic [OPND_W-1:0] cmp_lhs,
  input  logic [OPND_W-1:0] cmp_rhs,
  input  logic              cmp_signed,
  input  logic              cmp_ovf_sticky,
  input  logic              bop_vld,
  input  logic [2:0]        bop_op,
  input  logic [IDX_W-1:0]  bop_src_a,
  input  logic [IDX_W-1:0]  bop_src_b,
  input  logic [IDX_W-1:0]  bop_dst,
  input  logic [IDX_W-1:0]  test_idx,
  output logic              test_bit,
  output logic [CR_W-1:0]   cr_out
);

  logic [1:0]      rst_sync;
  logic            core_rst_n;
  logic [CR_W-1:0] cr_q;
  logic [FW-1:0]   int_flg, cmp_flg;
  logic            bop_res;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync[1];

  cr_flag_gen #(.OPND_W(OPND_W)) u_int_flags (
    .lhs        (int_value),
    .rhs        ('0),
    .is_signed  (int_signed),
    .ovf_sticky (int_ovf_sticky),
    .flags      (int_flg)
  );

  cr_flag_gen #(.OPND_W(OPND_W)) u_cmp_flags (
    .lhs        (cmp_lhs),
    .rhs        (cmp_rhs),
    .is_signed  (cmp_signed),
    .ovf_sticky (cmp_ovf_sticky),
    .flags      (cmp_flg)
  );

  cr_bit_op #(.CR_W(CR_W), .IDX_W(IDX_W)) u_bop (
    .cr_cur (cr_q),
    .op     (bop_op),
    .src_a  (bop_src_a),
    .src_b  (bop_src_b),
    .result (bop_res)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic          cmp_hit_f, bop_hit_f, int_hit_f, fp_hit_f;
    logic [FW-1:0] field_q;

    assign cmp_hit_f = cmp_vld && (cmp_field == SEL_W'(f));
    assign bop_hit_f = bop_vld && (bop_dst[IDX_W-1:PW] == SEL_W'(f));
    assign int_hit_f = (f == 0) ? int_vld : 1'b0;
    assign fp_hit_f  = (f == 1) ? fp_vld  : 1'b0;

    cr_field_slot #(.FW(FW), .PW(PW)) u_slot (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .cmp_hit   (cmp_hit_f),
      .cmp_flags (cmp_flg),
      .bop_hit   (bop_hit_f),
      .bop_pos   (bop_dst[PW-1:0]),
      .bop_bit   (bop_res),
      .int_hit   (int_hit_f),
      .int_flags (int_flg),
      .fp_hit    (fp_hit_f),
      .fp_flags  (fp_flags),
      .field_q   (field_q)
    );

    assign cr_q[CR_W-1-f*FW -: FW] = field_q;
  end

  assign cr_out   = cr_q;
  assign test_bit = cr_q[CR_W-1-int'(test_idx)];

  // R1: register reads zero after any cycle spent in reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !core_rst_n |=> cr_q == '0);

  // R10: integer and floating-point updates coexist in separate fields
  a_r10_int_fp_together: assert property (@(posedge clk) disable iff (!core_rst_n)
    (int_vld && fp_vld && !cmp_vld && !bop_vld)
      |=> (cr_q[CR_W-1 -: FW] == $past(int_flg)) && (cr_q[CR_W-1-FW -: FW] == $past(fp_flags)));

endmodule

// File: tb/sim_cr_field_unit.sv
module sim_cr_field_unit;

  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          int_vld, int_signed, int_ovf_sticky;
  logic [OW-1:0] int_value;
  logic          fp_vld;
  logic [3:0]    fp_flags;
  logic          cmp_vld, cmp_signed, cmp_ovf_sticky;
  logic [2:0]    cmp_field;
  logic [OW-1:0] cmp_lhs, cmp_rhs;
  logic          bop_vld;
  logic [2:0]    bop_op;
  logic [4:0]    bop_src_a, bop_src_b, bop_dst, test_idx;
  logic          test_bit;
  logic [31:0]   cr_out;

  logic [31:0] model;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #2 clk = ~clk;

  cr_field_unit #(.NUM_FIELDS(8), .OPND_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .int_vld(int_vld), .int_value(int_value), .int_signed(int_signed),
    .int_ovf_sticky(int_ovf_sticky),
    .fp_vld(fp_vld), .fp_flags(fp_flags),
    .cmp_vld(cmp_vld), .cmp_field(cmp_field), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
    .cmp_signed(cmp_signed), .cmp_ovf_sticky(cmp_ovf_sticky),
    .bop_vld(bop_vld), .bop_op(bop_op), .bop_src_a(bop_src_a),
    .bop_src_b(bop_src_b), .bop_dst(bop_dst),
    .test_idx(test_idx), .test_bit(test_bit), .cr_out(cr_out)
  );

  function automatic logic [3:0] exp_flags(input logic [OW-1:0] a, input logic [OW-1:0] b,
                                           input logic sgn, input logic so);
    int ia, ib;
    ia = int'(a);
    ib = int'(b);
    if (sgn && a[OW-1]) ia = ia - (1 << OW);
    if (sgn && b[OW-1]) ib = ib - (1 << OW);
    return {ia < ib, ia > ib, ia == ib, so};
  endfunction

  function automatic logic exp_bop(input logic [2:0] op, input logic a, input logic b);
    case (op)
      3'd0: return a & b;
      3'd1: return a | b;
      3'd2: return a ^ b;
      3'd3: return !(a & b);
      3'd4: return !(a | b);
      3'd5: return a == b;
      3'd6: return a & !b;
      default: return a | !b;
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    int_vld = 0; fp_vld = 0; cmp_vld = 0; bop_vld = 0;
  endtask

  // apply current request inputs for one edge, update model, then compare
  task automatic tick(input string req);
    logic [31:0] nm;
    nm = model;
    for (int f = 0; f < 8; f++) begin
      if (cmp_vld && cmp_field == 3'(f))
        nm[31-4*f -: 4] = exp_flags(cmp_lhs, cmp_rhs, cmp_signed, cmp_ovf_sticky);
      else if (bop_vld && int'(bop_dst) / 4 == f)
        nm[31-int'(bop_dst)] = exp_bop(bop_op, model[31-int'(bop_src_a)], model[31-int'(bop_src_b)]);
      else if (f == 0 && int_vld)
        nm[31:28] = exp_flags(int_value, '0, int_signed, int_ovf_sticky);
      else if (f == 1 && fp_vld)
        nm[27:24] = fp_flags;
    end
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    model = nm;
    check32(req, cr_out, model);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    int_value = '0; int_signed = 0; int_ovf_sticky = 0; fp_flags = '0;
    cmp_field = '0; cmp_lhs = '0; cmp_rhs = '0; cmp_signed = 0; cmp_ovf_sticky = 0;
    bop_op = '0; bop_src_a = '0; bop_src_b = '0; bop_dst = '0; test_idx = '0;
    model = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R1 reset clear", cr_out, 32'h0);

    // R5: every operand pair, both signedness modes, rotating target field
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          cmp_vld = 1; cmp_signed = s[0]; cmp_lhs = OW'(a); cmp_rhs = OW'(b);
          cmp_field = 3'(a + b); cmp_ovf_sticky = a[0] ^ b[1];
          tick("R5 compare");
        end

    // R2/R8: every bit index read through the test port matches the MSB-first mapping
    for (int i = 0; i < 32; i++) begin
      test_idx = 5'(i);
      #1;
      check32("R8 R2 test bit", {31'b0, test_bit}, {31'b0, model[31-i]});
    end

    // R3: integer update into field 0, all values, both modes, both overflow values
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 16; v++)
        for (int o = 0; o < 2; o++) begin
          int_vld = 1; int_value = OW'(v); int_signed = s[0]; int_ovf_sticky = o[0];
          tick("R3 integer update");
        end

    // R4: every floating-point nibble into field 1
    for (int v = 0; v < 16; v++) begin
      fp_vld = 1; fp_flags = 4'(v);
      tick("R4 fp update");
    end

    // R6: all functions, every destination, chained sources
    for (int op = 0; op < 8; op++)
      for (int d = 0; d < 32; d++) begin
        bop_vld = 1; bop_op = 3'(op); bop_dst = 5'(d);
        bop_src_a = 5'(d * 7 + op); bop_src_b = 5'(d * 3 + 11);
        tick("R6 bit op");
      end
    // R6: destination equals a source (reads pre-edge value)
    bop_vld = 1; bop_op = 3'd4; bop_dst = 5'd9; bop_src_a = 5'd9; bop_src_b = 5'd9;
    tick("R6 self nor");

    // R7: compare + bit op + integer on field 0
    cmp_vld = 1; cmp_field = 3'd0; cmp_lhs = 4'd3; cmp_rhs = 4'd5; cmp_signed = 0; cmp_ovf_sticky = 1;
    bop_vld = 1; bop_op = 3'd7; bop_dst = 5'd2; bop_src_a = 5'd20; bop_src_b = 5'd21;
    int_vld = 1; int_value = 4'd0; int_signed = 1; int_ovf_sticky = 0;
    tick("R7 cmp over bop and int");
    // R7: bit op over integer on field 0
    bop_vld = 1; bop_op = 3'd3; bop_dst = 5'd1; bop_src_a = 5'd0; bop_src_b = 5'd3;
    int_vld = 1; int_value = 4'd9; int_signed = 1; int_ovf_sticky = 1;
    tick("R7 bop over int");
    // R7: compare and bit op on field 1 beat fp
    cmp_vld = 1; cmp_field = 3'd1; cmp_lhs = 4'd15; cmp_rhs = 4'd1; cmp_signed = 1; cmp_ovf_sticky = 0;
    fp_vld = 1; fp_flags = 4'b1111;
    tick("R7 cmp over fp");
    bop_vld = 1; bop_op = 3'd1; bop_dst = 5'd7; bop_src_a = 5'd4; bop_src_b = 5'd5;
    fp_vld = 1; fp_flags = 4'b0000;
    tick("R7 bop over fp");

    // R10: independent fields written in one edge
    int_vld = 1; int_value = 4'd12; int_signed = 0; int_ovf_sticky = 1;
    fp_vld = 1; fp_flags = 4'b0101;
    cmp_vld = 1; cmp_field = 3'd6; cmp_lhs = 4'd8; cmp_rhs = 4'd7; cmp_signed = 1; cmp_ovf_sticky = 0;
    bop_vld = 1; bop_op = 3'd5; bop_dst = 5'd31; bop_src_a = 5'd0; bop_src_b = 5'd5;
    tick("R10 four fields together");

    // R9: idle cycles leave the register untouched
    for (int k = 0; k < 4; k++) begin
      cmp_lhs = OW'(k); int_value = OW'(k + 3); fp_flags = 4'(k); bop_dst = 5'(k);
      tick("R9 hold");
    end

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    model = '0;
    check32("R1 reset reapplied", cr_out, model);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R1 after release", cr_out, model);

    finish_run();
  end

endmodule